// File: doc/BRIEF.md
# Oversampled Serial Character Receiver With Noise Detection

This block recovers 8-bit asynchronous characters from one serial input line. A clock-enable pulse, `tick16`, arrives sixteen times per bit period. Each bit period is split into sixteen slots, numbered 1 to 16. A start bit counts only when it follows at least three idle highs. It must then pass a three-point check early in its period. Each later bit takes the majority of three samples around mid-bit.

The receiver counts a sample as noise in two cases: the start check sees exactly one high, or the three mid-bit samples of a data or stop bit do not agree. The slot counter restarts on each accepted start edge. When a bit voted high is followed by a falling edge close to the next bit boundary, the counter restarts there too. This lets the receiver follow a transmitter whose rate is off by about one slot per bit.

A finished character goes to a holding register and raises a full flag. A read strobe clears that flag and the status flags that go with it. An interrupt request follows the full flag while the enable input is high.

Top module: `uart_os_rx`

## Requirements
- R1: A falling edge starts a frame only if at least three consecutive high samples came before it. The low tick is slot 1 of the start bit.
- R2: The start bit is accepted when the samples at slots 3, 5 and 7 hold at most one high. If they hold two or more highs, the receiver goes back to searching and no character is produced.
- R3: An accepted start whose slot 3/5/7 samples contain exactly one high (patterns 001, 010, 100) sets the noise flag of that character. Pattern 000 does not.
- R4: Each of the eight data bits, sent LSB first, takes the majority value of its samples at slots 8, 9 and 10.
- R5: If the slot 8/9/10 samples of any data bit or of the stop bit disagree, the noise flag of the character is set.
- R6: The stop bit is voted like a data bit. A low result sets the framing-error flag.
- R7: After a bit that voted high, a falling edge seen in slots 1 to 7 of the next bit, or after slot 10 of the same bit, realigns the slot counter so that the edge tick becomes slot 1 of the next bit. Frames sent at 15 or 17 ticks per bit are then received correctly for alternating data.
- R8: When the stop bit has been voted, the data byte moves to `rx_data` and `rx_full` is set. `rx_data` changes at no other time.
- R9: `irq` is high one cycle after `rx_ie` and the full flag are both high, and is never high while `rx_full` is low.
- R10: A `rd_strobe` pulse clears `rx_full`, `noise_flag`, `frame_err`, `overrun` and `irq`, unless a character completes in the same cycle.
- R11: A character that completes while `rx_full` is still set (with no read that cycle) overwrites `rx_data` and sets `overrun`.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sampling enable, sixteen pulses per bit period |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| rx_data | output | 8 | Last received character |
| rx_full | output | 1 | Holding register contains an unread character |
| noise_flag | output | 1 | Noise was seen in the held character |
| frame_err | output | 1 | Stop bit of the held character voted low |
| overrun | output | 1 | A character was overwritten before it was read |
| irq | output | 1 | Receive interrupt request |

## Verification
The assertions treat `rd_strobe` as a single-cycle pulse. When a read and a character completion land in the same cycle, the new character wins, and the read-clear and overrun properties are guarded against that case. The line-level properties assume `rxd` holds one value per tick period. The stimulus therefore changes `rxd` and pulses `tick16` at a falling clock edge, once every two cycles, and leaves at least six idle ticks between frames. This keeps every start edge qualified, except in the runs that test qualification on purpose.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  function automatic logic split3(input logic [2:0] s);
    return (s != 3'b000) && (s != 3'b111);
  endfunction

  function automatic logic [1:0] highs3(input logic [2:0] s);
    return {1'b0, s[0]} + {1'b0, s[1]} + {1'b0, s[2]};
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
// Captures the line at two chosen slots; the third member of the vector
// is the live line, valid in the tick that follows the second capture.
module uart_rx_sampler #(
  parameter int SLOT_W = 5,
  parameter int P0     = 8,
  parameter int P1     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [SLOT_W-1:0] slot,
  input  logic              line,
  output logic [2:0]        vec
);
  logic r0, r1;

  always_ff @(posedge clk) begin
    if (rst) begin
      r0 <= 1'b1;
      r1 <= 1'b1;
    end else if (tick) begin
      if (slot == SLOT_W'(P0)) r0 <= line;
      if (slot == SLOT_W'(P1)) r1 <= line;
    end
  end

  assign vec = {r0, r1, line};
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OSR       = 16,
  parameter int IDLE_ONES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              noise,
  output logic              ferr
);
  localparam int SLOT_W = $clog2(OSR + 1);
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int ONES_W = $clog2(IDLE_ONES + 1);
  localparam int VB     = OSR / 2 + 1;
  localparam int VA     = VB - 1;
  localparam int VC     = VB + 1;
  localparam int SC     = OSR / 2 - 1;
  localparam int SB     = SC - 2;
  localparam int SA     = SC - 4;
  localparam logic [SLOT_W-1:0] SLOT_FIRST = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_NEXT  = SLOT_W'(2);

  rx_state_e         st;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic [ONES_W-1:0] ones;
  logic              nacc, armed, prev;
  logic [2:0]        svec, dvec;

  uart_rx_sampler #(.SLOT_W(SLOT_W), .P0(SA), .P1(SB)) u_start_smp (
    .clk(clk), .rst(rst), .tick(tick), .slot(slot), .line(line), .vec(svec)
  );

  uart_rx_sampler #(.SLOT_W(SLOT_W), .P0(VA), .P1(VB)) u_bit_smp (
    .clk(clk), .rst(rst), .tick(tick), .slot(slot), .line(line), .vec(dvec)
  );

  logic       at_sc, at_vc, last_slot, fall, early_win, late_win, resync;
  logic       vbit, vsplit, last_idx;
  logic [1:0] shigh;

  assign at_sc     = (slot == SLOT_W'(SC));
  assign at_vc     = (slot == SLOT_W'(VC));
  assign last_slot = (slot == SLOT_W'(OSR));
  assign fall      = prev & ~line;
  assign early_win = (slot <= SLOT_W'(SC));
  assign late_win  = (slot > SLOT_W'(VC));
  assign resync    = ((st == ST_DATA) || (st == ST_STOP)) && armed && fall &&
                     (early_win || late_win);
  assign vbit      = maj3(dvec);
  assign vsplit    = split3(dvec);
  assign shigh     = highs3(svec);
  assign last_idx  = (idx == IDX_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_HUNT;
      slot  <= '0;
      idx   <= '0;
      shreg <= '0;
      ones  <= '0;
      nacc  <= 1'b0;
      armed <= 1'b0;
      prev  <= 1'b1;
      done  <= 1'b0;
      data  <= '0;
      noise <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev <= line;
        case (st)
          ST_HUNT: begin
            if (!line && (ones >= ONES_W'(IDLE_ONES))) begin
              st   <= ST_START;
              slot <= SLOT_NEXT;
              nacc <= 1'b0;
              ones <= '0;
            end else if (!line) begin
              ones <= '0;
            end else if (ones < ONES_W'(IDLE_ONES)) begin
              ones <= ones + 1'b1;
            end
          end
          ST_START: begin
            slot <= slot + 1'b1;
            if (at_sc) begin
              if (shigh > 2'd1) begin
                st   <= ST_HUNT;
                ones <= '0;
              end else begin
                nacc <= (shigh == 2'd1);
              end
            end
            if (last_slot) begin
              st    <= ST_DATA;
              slot  <= SLOT_FIRST;
              idx   <= '0;
              armed <= 1'b0;
            end
          end
          ST_DATA, ST_STOP: begin
            if (resync) begin
              slot  <= SLOT_NEXT;
              armed <= 1'b0;
              if (late_win && (st == ST_DATA)) begin
                if (last_idx) st <= ST_STOP;
                else          idx <= idx + 1'b1;
              end
            end else begin
              if (last_slot) begin
                slot <= SLOT_FIRST;
                if (st == ST_DATA) begin
                  if (last_idx) st <= ST_STOP;
                  else          idx <= idx + 1'b1;
                end
              end else begin
                slot <= slot + 1'b1;
              end
              if (at_vc) begin
                armed <= vbit;
                nacc  <= nacc | vsplit;
                if (st == ST_DATA) begin
                  shreg <= {vbit, shreg[DATA_W-1:1]};
                end else begin
                  done  <= 1'b1;
                  data  <= shreg;
                  noise <= nacc | vsplit;
                  ferr  <= ~vbit;
                  st    <= ST_HUNT;
                  ones  <= '0;
                end
              end
            end
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] d_in,
  input  logic              n_in,
  input  logic              f_in,
  input  logic              ie,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              noise,
  output logic              ferr,
  output logic              ovr,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      full  <= 1'b0;
      noise <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (done) begin
        data  <= d_in;
        full  <= 1'b1;
        noise <= n_in;
        ferr  <= f_in;
        ovr   <= full & ~rd;
      end else if (rd) begin
        full  <= 1'b0;
        noise <= 1'b0;
        ferr  <= 1'b0;
        ovr   <= 1'b0;
      end
      irq <= ie & (done | (full & ~rd));
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int IDLE_ONES   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              rx_ie,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              noise_flag,
  output logic              frame_err,
  output logic              overrun,
  output logic              irq
);
  logic              rxd_s;
  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  logic              fr_noise;
  logic              fr_ferr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rxd_s)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR), .IDLE_ONES(IDLE_ONES)) u_frame (
    .clk(clk), .rst(rst), .tick(tick16), .line(rxd_s),
    .done(fr_done), .data(fr_data), .noise(fr_noise), .ferr(fr_ferr)
  );

  uart_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .done(fr_done), .d_in(fr_data), .n_in(fr_noise),
    .f_in(fr_ferr), .ie(rx_ie), .rd(rd_strobe),
    .data(rx_data), .full(rx_full), .noise(noise_flag), .ferr(frame_err),
    .ovr(overrun), .irq(irq)
  );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_strobe,
  input logic              rx_ie,
  input logic              frame_done,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              noise_flag,
  input logic              frame_err,
  input logic              overrun,
  input logic              irq
);
  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rx_full && !irq && !overrun && !noise_flag && !frame_err));

  // R8
  done_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> rx_full);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(rx_data));

  // R9
  irq_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> rx_full);

  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ie && rx_full && !rd_strobe) |=> irq);

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frame_done) |=>
      (!rx_full && !noise_flag && !frame_err && !overrun && !irq));

  // R11
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rx_full && !rd_strobe) |=> overrun);

  // R11
  overrun_full_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> rx_full);
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rx_ie(rx_ie),
  .frame_done(fr_done), .rx_data(rx_data), .rx_full(rx_full),
  .noise_flag(noise_flag), .frame_err(frame_err), .overrun(overrun), .irq(irq)
);

// File: tb/tb_uart_os_rx.sv
module tb_uart_os_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_ie = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, noise_flag, frame_err, overrun, irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  uart_os_rx dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .rx_ie(rx_ie),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
    .noise_flag(noise_flag), .frame_err(frame_err), .overrun(overrun), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tk(input logic v);
    @(negedge clk);
    rxd = v;
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic hold_line(input logic v, input int n);
    for (int i = 0; i < n; i++) tk(v);
  endtask

  task automatic rd();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  // glitch: bit index (0..7 data, 8 stop) whose slot-9 sample is inverted, -1 none
  task automatic send(input logic [7:0] d, input logic stp, input int per,
                      input int glitch, input logic [2:0] pat);
    for (int i = 0; i < per; i++) begin
      logic v;
      v = 1'b0;
      if (i == 2) v = pat[2];
      if (i == 4) v = pat[1];
      if (i == 6) v = pat[0];
      tk(v);
    end
    for (int b = 0; b < 9; b++) begin
      for (int i = 0; i < per; i++) begin
        logic v;
        v = (b < 8) ? d[b] : stp;
        if (b == glitch && i == 8) v = ~v;
        tk(v);
      end
    end
    hold_line(1'b1, 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 full", rx_full, 0);
    chk("R12 flags", {noise_flag, frame_err, overrun, irq}, 0);
    chk("R12 data", rx_data, 0);
    hold_line(1'b1, 8);

    // R4 R8 R10: every byte value, clean timing
    for (int d = 0; d < 256; d++) begin
      send(8'(d), 1'b1, 16, -1, 3'b000);
      chk("R4 data", rx_data, d);
      chk("R8 full", rx_full, 1);
      chk("R3 clean noise", noise_flag, 0);
      chk("R6 ferr clear", frame_err, 0);
      chk("R9 irq disabled", irq, 0);
      rd();
      chk("R10 full cleared", rx_full, 0);
    end

    // R2 R3: start-check patterns
    for (int p = 0; p < 8; p++) begin
      int h;
      h = (p & 1) + ((p >> 1) & 1) + ((p >> 2) & 1);
      if (h <= 1) begin
        send(8'hA5 ^ 8'(p), 1'b1, 16, -1, 3'(p));
        chk("R2 accepted", rx_full, 1);
        chk("R2 data", rx_data, 8'hA5 ^ 8'(p));
        chk("R3 start noise", noise_flag, (h == 1) ? 1 : 0);
        rd();
      end else begin
        for (int i = 0; i < 7; i++) begin
          logic v;
          v = 1'b0;
          if (i == 2) v = p[2];
          if (i == 4) v = p[1];
          if (i == 6) v = p[0];
          tk(v);
        end
        hold_line(1'b1, 40);
        chk("R2 rejected", rx_full, 0);
      end
    end

    // R5: single disagreeing sample in each data bit and the stop bit
    for (int g = 0; g < 9; g++) begin
      send(8'h3C, 1'b1, 16, g, 3'b000);
      chk("R5 data kept", rx_data, 8'h3C);
      chk("R5 noise", noise_flag, 1);
      chk("R5 ferr", frame_err, 0);
      rd();
      chk("R10 noise cleared", noise_flag, 0);
    end

    // R6 framing error
    send(8'h81, 1'b0, 16, -1, 3'b000);
    chk("R6 ferr", frame_err, 1);
    chk("R6 data", rx_data, 8'h81);
    rd();
    chk("R10 ferr cleared", frame_err, 0);

    // R7 rate mismatch on alternating data
    send(8'h55, 1'b1, 15, -1, 3'b000);
    chk("R7 fast 55", rx_data, 8'h55);
    chk("R7 fast 55 ferr", frame_err, 0);
    rd();
    send(8'h55, 1'b1, 17, -1, 3'b000);
    chk("R7 slow 55", rx_data, 8'h55);
    rd();
    send(8'hAA, 1'b1, 15, -1, 3'b000);
    chk("R7 fast AA", rx_data, 8'hAA);
    rd();
    send(8'hAA, 1'b1, 17, -1, 3'b000);
    chk("R7 slow AA", rx_data, 8'hAA);
    chk("R7 slow AA ferr", frame_err, 0);
    rd();

    // R11 overrun
    send(8'h12, 1'b1, 16, -1, 3'b000);
    chk("R11 no overrun yet", overrun, 0);
    send(8'h34, 1'b1, 16, -1, 3'b000);
    chk("R11 overrun", overrun, 1);
    chk("R11 data replaced", rx_data, 8'h34);
    rd();
    chk("R10 overrun cleared", overrun, 0);

    // R9 interrupt request
    rx_ie = 1'b1;
    send(8'h5A, 1'b1, 16, -1, 3'b000);
    chk("R9 irq set", irq, 1);
    @(negedge clk);
    rx_ie = 1'b0;
    @(negedge clk);
    chk("R9 irq follows enable", irq, 0);
    chk("R9 full held", rx_full, 1);
    rx_ie = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 irq back", irq, 1);
    rd();
    chk("R10 irq cleared", irq, 0);
    rx_ie = 1'b0;

    // R1 idle qualification
    hold_line(1'b0, 200);
    rd();
    hold_line(1'b1, 2);
    hold_line(1'b0, 200);
    hold_line(1'b1, 20);
    chk("R1 two highs no start", rx_full, 0);
    hold_line(1'b0, 200);
    rd();
    hold_line(1'b1, 3);
    hold_line(1'b0, 200);
    chk("R1 three highs start", rx_full, 1);
    chk("R1 zero frame ferr", frame_err, 1);
    chk("R1 zero frame data", rx_data, 0);
    hold_line(1'b1, 20);
    rd();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule